// File: doc/BRIEF.md
# Double-Buffered Stream Pointer Manager

This block keeps the two buffer pointers of an audio sample stream that moves its data to or from memory in fixed-length blocks. Software loads a next-buffer pointer through a small write port, then writes a nonzero end index to start the stream. That write copies the loaded pointer into the current pointer and empties the next slot. Software then loads the following pointer while the first buffer is in use. Each per-sample request makes one or two memory accesses, depending on the memory word size. The block gives the byte address, the access size and a lock marker for each access.

When the sample at the end index has been moved, the block copies the next pointer into the current pointer and clears the next slot, which then reads back as zero. It raises a one-cycle completion pulse and sets a completion flag. If software has not reloaded the next slot by that boundary, a sticky pointer error is raised and the stream stops. A buffer that would reach the top address of the address space raises a sticky range error and does not run, so no access ever wraps around.

Top module: `dma_ptr_mgr`

## Requirements
- R1: After reset the stream is stopped, no access is offered, all flags are low and the next slot reads zero. A write of a nonzero end index (select 1), made while the next slot holds a nonzero pointer, starts the stream: the current address becomes that pointer and the next slot reads zero. A zero end index stops the stream.
- R2: A nonzero end-index write made while the next slot is empty sets the pointer error flag and leaves the stream stopped.
- R3: With 16-bit memory words (`mem24` low), each accepted sample request gives one halfword access (`accSize`=1) with `accLock` low, and the address then rises by 2.
- R4: With 24-bit memory words, each sample gives a byte access (`accSize`=0) at the current address, followed in the next cycle by a halfword access at address+1. `accLock` is high on both, and the address then rises by 3.
- R5: After end-index+1 samples, the current address becomes the next pointer and the next slot reads zero. `donePulse` is high for exactly one cycle and `doneIrq` sets.
- R6: If the next slot is empty at a buffer boundary, `ptrErr` sets and stays set until a software clear. The stream stops, no completion pulse is issued, and later sample requests make no access.
- R7: A next-pointer write (select 0) clears `doneIrq`. A software set of the completion flag in the same cycle as that write is ignored.
- R8: `flagSet`/`flagClr` bit 0 acts on `doneIrq`, bit 1 on `ptrErr` and bit 2 on `rangeErr`. A software set or clear alone sets or clears the flag. A clear in the same cycle as a hardware set condition is ignored.
- R9: If a buffer's last byte (pointer + (end index+1) x bytes-per-sample - 1, with 2 or 3 bytes per sample) would be at or above the top address 2^ADDR_W-1, `rangeErr` sets and the stream does not run. No access ever covers the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 next pointer, 1 end index |
| wrData | input | ADDR_W | Write data (the end index uses the low LEN_W bits) |
| mem24 | input | 1 | 1: 24-bit memory words, 0: 16-bit |
| sampleReq | input | 1 | Per-sample transfer request |
| flagSet | input | 3 | Software set of {rangeErr, ptrErr, doneIrq} |
| flagClr | input | 3 | Software clear of {rangeErr, ptrErr, doneIrq} |
| curAddr | output | ADDR_W | Current byte address |
| accValid | output | 1 | An access is being offered this cycle |
| accSize | output | 1 | 0 byte, 1 halfword |
| accLock | output | 1 | Access is part of a locked pair |
| nextPtrRd | output | ADDR_W | Read-back of the next-pointer slot |
| running | output | 1 | Stream enabled |
| donePulse | output | 1 | One-cycle buffer completion |
| doneIrq | output | 1 | Sticky completion flag |
| ptrErr | output | 1 | Sticky missing-pointer error |
| rangeErr | output | 1 | Sticky address-limit error |

## Verification
Register writes and flag operations show their effect on the outputs one clock after the edge that samples them. A sample request shows its first access one clock after its edge. In 24-bit mode the second access follows one clock later. The completion pulse, the new current address and the empty next slot all appear one clock after the final halfword access. The bench drives inputs on the falling edge and reads the outputs on the next falling edge after each rising edge. It walks every sample with tasks that predict the address, size and lock of each access in that cycle. Conflict cases hold the competing flag operation over the exact edge where the hardware condition occurs.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BYTE, ST_HALF} accState_t;

  // Strobes sent from the control to the pointer datapath
  typedef struct packed {
    logic writeNext;
    logic loadCur;
    logic stepByte;
    logic stepHalf;
  } ptrStrobe_t;

  localparam logic SEL_NEXT = 1'b0;
  localparam logic SEL_END  = 1'b1;
endpackage

// File: rtl/dma_ptr_dp.sv
module dma_ptr_dp
  import dma_ptr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [LEN_W-1:0]  checkLen,
  input  logic              checkWide,
  output logic [ADDR_W-1:0] curPtr,
  output logic [ADDR_W-1:0] nextPtr,
  output logic              nextValid,
  output logic              rangeBad
);
  localparam int EXT_W = ADDR_W + LEN_W + 3;
  localparam logic [EXT_W-1:0] LIMIT = (EXT_W'(1) << ADDR_W) - EXT_W'(1);

  logic [EXT_W-1:0] spanBytes;
  logic [EXT_W-1:0] lastByte;

  always_comb begin
    spanBytes = (EXT_W'(checkLen) + EXT_W'(1)) * (checkWide ? EXT_W'(3) : EXT_W'(2));
    lastByte  = EXT_W'(nextPtr) + spanBytes - EXT_W'(1);
    rangeBad  = (lastByte >= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPtr   <= '0;
      nextValid <= 1'b0;
    end else if (strobe.writeNext) begin
      nextPtr   <= wrData;
      nextValid <= |wrData;
    end else if (strobe.loadCur) begin
      nextPtr   <= '0;
      nextValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                curPtr <= '0;
    else if (strobe.loadCur)  curPtr <= nextPtr;
    else if (strobe.stepByte) curPtr <= curPtr + ADDR_W'(1);
    else if (strobe.stepHalf) curPtr <= curPtr + ADDR_W'(2);
  end
endmodule

// File: rtl/dma_ptr_ctrl.sv
module dma_ptr_ctrl
  import dma_ptr_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [LEN_W-1:0] wrLen,
  input  logic             mem24,
  input  logic             sampleReq,
  input  logic [2:0]       flagSet,
  input  logic [2:0]       flagClr,
  input  logic             nextValid,
  input  logic             rangeBad,
  output ptrStrobe_t       strobe,
  output logic [LEN_W-1:0] checkLen,
  output logic             checkWide,
  output logic             accValid,
  output logic             accSize,
  output logic             accLock,
  output logic             running,
  output logic             donePulse,
  output logic             doneIrq,
  output logic             ptrErr,
  output logic             rangeErr
);
  accState_t        state;
  logic [LEN_W-1:0] endIdx;
  logic [LEN_W-1:0] sampleIdx;
  logic             wideQ;

  logic ptrWrite, cfgWrite, cfgStart, cfgMiss;
  logic lastSample, boundaryOk, boundaryMiss, rangeHit;

  always_comb begin
    ptrWrite     = wrEn && (wrSel == SEL_NEXT);
    cfgWrite     = wrEn && (wrSel == SEL_END);
    cfgStart     = cfgWrite && (wrLen != '0) && nextValid;
    cfgMiss      = cfgWrite && (wrLen != '0) && !nextValid;
    lastSample   = (state == ST_HALF) && (sampleIdx == endIdx) && !cfgWrite;
    boundaryOk   = lastSample && nextValid;
    boundaryMiss = lastSample && !nextValid;

    strobe.writeNext = ptrWrite;
    strobe.loadCur   = cfgStart || boundaryOk;
    strobe.stepByte  = (state == ST_BYTE);
    strobe.stepHalf  = (state == ST_HALF) && !lastSample;

    checkLen  = cfgWrite ? wrLen : endIdx;
    checkWide = mem24;
    rangeHit  = strobe.loadCur && rangeBad;

    accValid = (state != ST_IDLE);
    accSize  = (state == ST_HALF);
    accLock  = (state == ST_BYTE) || ((state == ST_HALF) && wideQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      endIdx    <= '0;
      sampleIdx <= '0;
      wideQ     <= 1'b0;
      running   <= 1'b0;
    end else if (cfgWrite) begin
      endIdx    <= wrLen;
      sampleIdx <= '0;
      state     <= ST_IDLE;
      running   <= cfgStart && !rangeBad;
    end else begin
      unique case (state)
        ST_IDLE: if (sampleReq && running) begin
          state <= mem24 ? ST_BYTE : ST_HALF;
          wideQ <= mem24;
        end
        ST_BYTE: state <= ST_HALF;
        ST_HALF: begin
          state <= ST_IDLE;
          if (lastSample) begin
            sampleIdx <= '0;
            if (!nextValid || rangeBad) running <= 1'b0;
          end else begin
            sampleIdx <= sampleIdx + LEN_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Flags: hardware set beats software clear; pointer write beats software set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      donePulse <= 1'b0;
      doneIrq   <= 1'b0;
      ptrErr    <= 1'b0;
      rangeErr  <= 1'b0;
    end else begin
      donePulse <= boundaryOk;
      doneIrq   <= boundaryOk || (!ptrWrite && !flagClr[0] && (doneIrq || flagSet[0]));
      ptrErr    <= boundaryMiss || cfgMiss || flagSet[1] || (ptrErr && !flagClr[1]);
      rangeErr  <= rangeHit || flagSet[2] || (rangeErr && !flagClr[2]);
    end
  end
endmodule

// File: rtl/dma_ptr_mgr.sv
module dma_ptr_mgr
  import dma_ptr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              mem24,
  input  logic              sampleReq,
  input  logic [2:0]        flagSet,
  input  logic [2:0]        flagClr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              accValid,
  output logic              accSize,
  output logic              accLock,
  output logic [ADDR_W-1:0] nextPtrRd,
  output logic              running,
  output logic              donePulse,
  output logic              doneIrq,
  output logic              ptrErr,
  output logic              rangeErr
);
  ptrStrobe_t       strobe;
  logic [LEN_W-1:0] checkLen;
  logic             checkWide, nextValid, rangeBad;

  dma_ptr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrLen(wrData[LEN_W-1:0]), .mem24(mem24), .sampleReq(sampleReq),
    .flagSet(flagSet), .flagClr(flagClr), .nextValid(nextValid),
    .rangeBad(rangeBad), .strobe(strobe), .checkLen(checkLen),
    .checkWide(checkWide), .accValid(accValid), .accSize(accSize),
    .accLock(accLock), .running(running), .donePulse(donePulse),
    .doneIrq(doneIrq), .ptrErr(ptrErr), .rangeErr(rangeErr)
  );

  dma_ptr_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .checkLen(checkLen), .checkWide(checkWide), .curPtr(curAddr),
    .nextPtr(nextPtrRd), .nextValid(nextValid), .rangeBad(rangeBad)
  );
endmodule

// File: rtl/dma_ptr_mgr_chk.sv
module dma_ptr_mgr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        flagClr,
  input logic [ADDR_W-1:0] curAddr,
  input logic              accValid,
  input logic              accSize,
  input logic              accLock,
  input logic              running,
  input logic              donePulse,
  input logic              doneIrq,
  input logic              ptrErr
);
  localparam logic [ADDR_W:0] TOP = (ADDR_W+1)'((1 << ADDR_W) - 1);

  p_byte_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !accSize |-> accLock);

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> ({1'b0, curAddr} + (accSize ? (ADDR_W+1)'(2) : (ADDR_W+1)'(1))) <= TOP);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ptrErr && !flagClr[1] |=> ptrErr);

  p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !accValid);

  p_pulse_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> doneIrq);

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
endmodule

bind dma_ptr_mgr dma_ptr_mgr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .flagClr(flagClr), .curAddr(curAddr),
  .accValid(accValid), .accSize(accSize), .accLock(accLock),
  .running(running), .donePulse(donePulse), .doneIrq(doneIrq),
  .ptrErr(ptrErr)
);

// File: tb/dma_ptr_mgr_tb.sv
module dma_ptr_mgr_tb;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              wrSel = 1'b0;
  logic [ADDR_W-1:0] wrData = '0;
  logic              mem24 = 1'b0;
  logic              sampleReq = 1'b0;
  logic [2:0]        flagSet = '0;
  logic [2:0]        flagClr = '0;
  logic [ADDR_W-1:0] curAddr, nextPtrRd;
  logic accValid, accSize, accLock, running, donePulse, doneIrq, ptrErr, rangeErr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_ptr_mgr #(.ADDR_W(ADDR_W), .LEN_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .mem24(mem24), .sampleReq(sampleReq), .flagSet(flagSet), .flagClr(flagClr),
    .curAddr(curAddr), .accValid(accValid), .accSize(accSize), .accLock(accLock),
    .nextPtrRd(nextPtrRd), .running(running), .donePulse(donePulse),
    .doneIrq(doneIrq), .ptrErr(ptrErr), .rangeErr(rangeErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [ADDR_W-1:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] sampleAddr(input logic wide, input logic [ADDR_W-1:0] base, input int i);
    return base + ADDR_W'(i * (wide ? 3 : 2));
  endfunction

  task automatic doSample(input logic wide, input logic [ADDR_W-1:0] a);
    sampleReq = 1'b1;
    cyc();
    sampleReq = 1'b0;
    if (wide) begin
      chk("R4 byte valid", accValid, 1);
      chk("R4 byte addr", curAddr, a);
      chk("R4 byte size", accSize, 0);
      chk("R4 byte lock", accLock, 1);
      cyc();
      chk("R4 half addr", curAddr, a + 1);
      chk("R4 half size", accSize, 1);
      chk("R4 half lock", accLock, 1);
    end else begin
      chk("R3 valid", accValid, 1);
      chk("R3 addr", curAddr, a);
      chk("R3 size", accSize, 1);
      chk("R3 lock", accLock, 0);
    end
    cyc();
  endtask

  task automatic runBuffer(input logic wide, input int len, input logic [ADDR_W-1:0] base,
                           input logic expDone, input logic [ADDR_W-1:0] newBase);
    for (int i = 0; i <= len; i++) doSample(wide, sampleAddr(wide, base, i));
    chk("R5 done pulse", donePulse, expDone);
    if (expDone) begin
      chk("R5 promoted address", curAddr, newBase);
      chk("R5 next slot empty", nextPtrRd, 0);
      chk("R5 done flag", doneIrq, 1);
      cyc();
      chk("R5 pulse one cycle", donePulse, 0);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] ra, rb;
    logic rw;
    int rl;
    void'($urandom(32'h5eed_1234));
    @(negedge clk); cyc();
    rstN = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 reset running", running, 0);
    chk("R1 reset accValid", accValid, 0);
    chk("R1 reset flags", {doneIrq, ptrErr, rangeErr}, 0);
    chk("R1 reset next slot", nextPtrRd, 0);

    // R1 start, 16-bit buffer of 4 samples
    wr(0, 16'h0100);
    chk("R1 next readback", nextPtrRd, 16'h0100);
    wr(1, 3);
    chk("R1 running", running, 1);
    chk("R1 cur loaded", curAddr, 16'h0100);
    chk("R1 next consumed", nextPtrRd, 0);
    wr(0, 16'h0200);
    chk("R1 second next", nextPtrRd, 16'h0200);
    runBuffer(0, 3, 16'h0100, 1, 16'h0200);

    // R7 set coinciding with pointer write is ignored
    wrEn = 1'b1; wrSel = 1'b0; wrData = 16'h0300; flagSet = 3'b001;
    cyc();
    wrEn = 1'b0; flagSet = '0;
    chk("R7 auto clear wins", doneIrq, 0);
    chk("R7 next written", nextPtrRd, 16'h0300);
    // R8 lone set and clear
    flagSet = 3'b001; cyc(); flagSet = '0;
    chk("R8 set alone", doneIrq, 1);
    flagClr = 3'b001; cyc(); flagClr = '0;
    chk("R8 clear alone", doneIrq, 0);

    runBuffer(0, 3, 16'h0200, 1, 16'h0300);
    // R6 and R8: missing reload, clear held over the boundary edge
    flagClr = 3'b010;
    runBuffer(0, 3, 16'h0300, 0, 0);
    chk("R8 set beats clear", ptrErr, 1);
    flagClr = '0;
    chk("R6 stopped", running, 0);
    cyc();
    chk("R6 sticky", ptrErr, 1);
    sampleReq = 1'b1; cyc(); sampleReq = 1'b0;
    chk("R6 request ignored", accValid, 0);
    flagClr = 3'b010; cyc(); flagClr = '0;
    chk("R8 error clear", ptrErr, 0);

    // R4 24-bit buffer of 3 samples
    mem24 = 1'b1;
    wr(0, 16'h1000);
    wr(1, 2);
    wr(0, 16'h2000);
    runBuffer(1, 2, 16'h1000, 1, 16'h2000);

    // R1 stop, R2 start without pointer
    wr(1, 0);
    chk("R1 zero stops", running, 0);
    wr(1, 4);
    chk("R2 error", ptrErr, 1);
    chk("R2 not started", running, 0);
    flagClr = 3'b111; cyc(); flagClr = '0;

    // R9 range limit
    mem24 = 1'b0;
    wr(0, 16'hFFF0);
    wr(1, 7);
    chk("R9 range error", rangeErr, 1);
    chk("R9 not running", running, 0);
    sampleReq = 1'b1; cyc(); sampleReq = 1'b0;
    chk("R9 no access", accValid, 0);
    wr(0, 16'hFFEF);
    wr(1, 7);
    chk("R9 fits below top", running, 1);
    wr(0, 16'h0010);
    runBuffer(0, 7, 16'hFFEF, 1, 16'h0010);

    // Random buffers in both modes
    for (int k = 0; k < 12; k++) begin
      rw = 1'($urandom % 2);
      rl = 1 + int'($urandom % 6);
      ra = ADDR_W'(($urandom % 16'h4000) + 1);
      rb = ADDR_W'(($urandom % 16'h4000) + 1);
      wr(1, 0);
      flagClr = 3'b111; cyc(); flagClr = '0;
      mem24 = rw;
      wr(0, ra);
      wr(1, ADDR_W'(rl));
      chk("R1 random start", curAddr, ra);
      wr(0, rb);
      runBuffer(rw, rl, ra, 1, rb);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule